// File: doc/BRIEF.md
# Saturating Up/Down Counter Field with Threshold Flags

This block holds one counter field of a register bank. Two hardware request lines move the count: one adds an up-step, the other takes away a down-step. Each step is either a fixed value set at build time or a value that arrives on a step port, and each direction is chosen on its own. When both lines are high in the same cycle, the count moves by the difference between the two steps.

Each direction can be set to clamp at its own bound, or to wrap modulo 2^CNT_W. A wrap raises a one-cycle overflow or underflow pulse. Two level flags show whether the count is at or above the upper threshold, or at or below the lower threshold. Software reads the count on a read-data port and loads a new value with a write strobe. The write wins over any hardware request in the same cycle.

Top module: `sat_thresh_counter`

## Requirements
- R1: While rst_n is low at a clock edge, the count becomes 0 and both wrap pulses are 0.
- R2: With inc_req high alone, the count one cycle later is the old count plus the up-step: the parameter INC_STEP when INC_PORT=0, or inc_val when INC_PORT=1.
- R3: With dec_req high alone, the count one cycle later is the old count minus the down-step: DEC_STEP when DEC_PORT=0, or dec_val when DEC_PORT=1.
- R4: With both requests high, the count moves by the up-step minus the down-step.
- R5: A high sw_wr_en loads sw_wr_data into the count on the next edge, whatever the request lines do. No wrap pulse is raised in that cycle, and sw_rd_data always shows the count.
- R6: When INC_SAT_EN=1 and the net move is upward, a result above INC_SAT is replaced by INC_SAT.
- R7: When DEC_SAT_EN=1 and the net move is downward, a result below DEC_SAT is replaced by DEC_SAT.
- R8: inc_thr_hit is high exactly while the count is greater than or equal to INC_THR.
- R9: dec_thr_hit is high exactly while the count is less than or equal to DEC_THR.
- R10: When INC_SAT_EN=0, an upward move past 2^CNT_W-1 wraps modulo 2^CNT_W and raises ovf_pulse for one cycle, together with the new count. When INC_SAT_EN=1, ovf_pulse stays low.
- R11: When DEC_SAT_EN=0, a downward move below 0 wraps modulo 2^CNT_W and raises udf_pulse for one cycle, together with the new count. When DEC_SAT_EN=1, udf_pulse stays low.
- R12: With no request and no write, the count holds and both pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inc_req | input | 1 | Upward request, active high |
| dec_req | input | 1 | Downward request, active high |
| inc_val | input | STEP_W | Up-step when INC_PORT=1 |
| dec_val | input | STEP_W | Down-step when DEC_PORT=1 |
| sw_wr_en | input | 1 | Software load strobe |
| sw_wr_data | input | CNT_W | Value loaded by software |
| sw_rd_data | output | CNT_W | Current count |
| inc_thr_hit | output | 1 | Count at or above INC_THR |
| dec_thr_hit | output | 1 | Count at or below DEC_THR |
| ovf_pulse | output | 1 | One-cycle pulse on an upward wrap |
| udf_pulse | output | 1 | One-cycle pulse on a downward wrap |

## Verification
The count register is the only state besides the two pulse flops. A wrong step, clamp or wrap decision therefore shows on sw_rd_data one cycle after the request, and the threshold flags follow it in the same cycle. A wrap that goes unreported, or a pulse that is raised without a wrap, shows on ovf_pulse or udf_pulse in the cycle the new count appears. A pulse held too long shows one cycle after that. Two configurations are exercised: fixed steps with both clamps enabled, and port steps with both clamps disabled on a narrow counter, so that wrapping can be reached.

// File: rtl/stc_pkg.sv
// Shared types for the saturating threshold counter.
package stc_pkg;

    // Wrap indication produced by the next-value logic.
    typedef struct packed {
        logic ovf;
        logic udf;
    } wrap_t;

endpackage

// File: rtl/stc_step_sel.sv
// Picks the step for one direction: a build-time constant or the port value.
// Assumes STEP_W is no wider than the counter that consumes the step.
module stc_step_sel #(
    parameter int unsigned          STEP_W   = 8,
    parameter bit                   USE_PORT = 1'b0,
    parameter logic [STEP_W-1:0]    FIXED    = 2
) (
    input  logic [STEP_W-1:0] port_val,
    output logic [STEP_W-1:0] step
);

    localparam logic [STEP_W-1:0] CONST_STEP = FIXED;

    // Parameter-controlled choice between the external and the fixed step.
    always_comb begin
        step = USE_PORT ? port_val : CONST_STEP;
    end

endmodule

// File: rtl/stc_next.sv
// Computes the next count from the current count and the requested steps.
// It applies clamping for each direction, or reports a wrap when clamping
// is off. Assumes INC_SAT >= DEC_SAT when both clamps are enabled.
module stc_next
    import stc_pkg::*;
#(
    parameter int unsigned       CNT_W      = 32,
    parameter int unsigned       STEP_W     = 8,
    parameter bit                INC_SAT_EN = 1'b1,
    parameter bit                DEC_SAT_EN = 1'b1,
    parameter logic [CNT_W-1:0]  INC_SAT    = 15,
    parameter logic [CNT_W-1:0]  DEC_SAT    = 5
) (
    input  logic [CNT_W-1:0]  cur,
    input  logic              inc_req,
    input  logic              dec_req,
    input  logic [STEP_W-1:0] inc_amt,
    input  logic [STEP_W-1:0] dec_amt,
    output logic [CNT_W-1:0]  nxt,
    output wrap_t             wrap
);

    localparam int unsigned EW = CNT_W + 2;
    localparam logic signed [EW-1:0] HI_BOUND = {2'b00, INC_SAT};
    localparam logic signed [EW-1:0] LO_BOUND = {2'b00, DEC_SAT};

    logic        [EW-1:0] up_e;
    logic        [EW-1:0] dn_e;
    logic signed [EW-1:0] sum;
    logic                 rising;
    logic                 falling;

    // Widens the active steps and forms the signed raw result.
    always_comb begin
        up_e    = inc_req ? {{(EW-STEP_W){1'b0}}, inc_amt} : '0;
        dn_e    = dec_req ? {{(EW-STEP_W){1'b0}}, dec_amt} : '0;
        sum     = signed'({2'b00, cur}) + signed'(up_e) - signed'(dn_e);
        rising  = up_e > dn_e;
        falling = dn_e > up_e;
    end

    // Applies the clamp or detects the wrap for the net direction of motion.
    always_comb begin
        nxt  = sum[CNT_W-1:0];
        wrap = '0;
        if (rising) begin
            if (INC_SAT_EN && (sum > HI_BOUND)) begin
                nxt = INC_SAT;
            end else if (sum[EW-2]) begin
                wrap.ovf = 1'b1;
            end
        end else if (falling) begin
            if (DEC_SAT_EN && (sum < LO_BOUND)) begin
                nxt = DEC_SAT;
            end else if (sum[EW-1]) begin
                wrap.udf = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sat_thresh_counter.sv
// Counter field of a register bank. It moves up and down on hardware
// requests, clamps or wraps in each direction, and gives level threshold
// flags and one-cycle wrap pulses. A software write loads the count and
// wins over the hardware requests. Reset is synchronous and active low.
module sat_thresh_counter
    import stc_pkg::*;
#(
    parameter int unsigned       CNT_W      = 32,
    parameter int unsigned       STEP_W     = 8,
    parameter bit                INC_PORT   = 1'b0,
    parameter bit                DEC_PORT   = 1'b0,
    parameter logic [STEP_W-1:0] INC_STEP   = 2,
    parameter logic [STEP_W-1:0] DEC_STEP   = 2,
    parameter bit                INC_SAT_EN = 1'b1,
    parameter bit                DEC_SAT_EN = 1'b1,
    parameter logic [CNT_W-1:0]  INC_SAT    = 15,
    parameter logic [CNT_W-1:0]  DEC_SAT    = 5,
    parameter logic [CNT_W-1:0]  INC_THR    = 10,
    parameter logic [CNT_W-1:0]  DEC_THR    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_req,
    input  logic              dec_req,
    input  logic [STEP_W-1:0] inc_val,
    input  logic [STEP_W-1:0] dec_val,
    input  logic              sw_wr_en,
    input  logic [CNT_W-1:0]  sw_wr_data,
    output logic [CNT_W-1:0]  sw_rd_data,
    output logic              inc_thr_hit,
    output logic              dec_thr_hit,
    output logic              ovf_pulse,
    output logic              udf_pulse
);

    logic [STEP_W-1:0] inc_amt;
    logic [STEP_W-1:0] dec_amt;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nxt;
    wrap_t             wrap_nxt;
    wrap_t             wrap_q;

    stc_step_sel #(.STEP_W(STEP_W), .USE_PORT(INC_PORT), .FIXED(INC_STEP)) i_up_step (
        .port_val (inc_val),
        .step     (inc_amt)
    );

    stc_step_sel #(.STEP_W(STEP_W), .USE_PORT(DEC_PORT), .FIXED(DEC_STEP)) i_dn_step (
        .port_val (dec_val),
        .step     (dec_amt)
    );

    stc_next #(
        .CNT_W(CNT_W), .STEP_W(STEP_W),
        .INC_SAT_EN(INC_SAT_EN), .DEC_SAT_EN(DEC_SAT_EN),
        .INC_SAT(INC_SAT), .DEC_SAT(DEC_SAT)
    ) i_next (
        .cur     (cnt_q),
        .inc_req (inc_req),
        .dec_req (dec_req),
        .inc_amt (inc_amt),
        .dec_amt (dec_amt),
        .nxt     (cnt_nxt),
        .wrap    (wrap_nxt)
    );

    // Count and wrap-pulse registers; the software load has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wrap_q <= '0;
        end else if (sw_wr_en) begin
            cnt_q  <= sw_wr_data;
            wrap_q <= '0;
        end else begin
            cnt_q  <= cnt_nxt;
            wrap_q <= wrap_nxt;
        end
    end

    // Level threshold flags and output mapping.
    always_comb begin
        sw_rd_data  = cnt_q;
        inc_thr_hit = cnt_q >= INC_THR;
        dec_thr_hit = cnt_q <= DEC_THR;
        ovf_pulse   = wrap_q.ovf;
        udf_pulse   = wrap_q.udf;
    end

    // R5: a load is seen on the read port one cycle later.
    p_wr_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en |=> sw_rd_data == $past(sw_wr_data));

    // R12: an idle cycle leaves the count unchanged and no pulses.
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr_en && !inc_req && !dec_req) |=> ($stable(sw_rd_data) && !ovf_pulse && !udf_pulse));

    // R10, R11: a move never wraps both ways at once.
    p_one_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_pulse, udf_pulse}));

    // Checks tied to the clamping variants.
    if (INC_SAT_EN) begin : g_hi_clamp
        // R6: starting within the upper bound, an upward move stays within it.
        p_hi_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!sw_wr_en && !dec_req && sw_rd_data <= INC_SAT) |=> sw_rd_data <= INC_SAT);
        // R10: no overflow pulse while clamping upward.
        p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !ovf_pulse);
    end
    if (DEC_SAT_EN) begin : g_lo_clamp
        // R7: starting within the lower bound, a downward move stays within it.
        p_lo_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!sw_wr_en && !inc_req && sw_rd_data >= DEC_SAT) |=> sw_rd_data >= DEC_SAT);
        // R11: no underflow pulse while clamping downward.
        p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !udf_pulse);
    end

endmodule

// File: tb/test_sat_thresh_counter.sv
// Scoreboard bench: the driver applies one operation per cycle and queues
// the expected result; a monitor compares each result a quarter cycle after
// the edge that produces it. Instance 0 uses fixed steps and clamping,
// instance 1 uses port steps and wraps on an 8-bit count.
module test_sat_thresh_counter;

    localparam int CLK_NS = 20;

    typedef struct {
        int          sel;
        longint      cnt;
        bit          ov;
        bit          uf;
        bit          ith;
        bit          dth;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_inc = 0, a_dec = 0, a_we = 0;
    logic [7:0]  a_iv = 0, a_dv = 0;
    logic [31:0] a_wd = 0;
    logic        b_inc = 0, b_dec = 0, b_we = 0;
    logic [7:0]  b_iv = 0, b_dv = 0;
    logic [7:0]  b_wd = 0;

    logic [31:0] a_cnt;
    logic        a_ith, a_dth, a_ov, a_uf;
    logic [7:0]  b_cnt;
    logic        b_ith, b_dth, b_ov, b_uf;

    int     n_chk = 0;
    int     n_fail = 0;
    longint mcnt [2];
    exp_t   q [$];

    always #(CLK_NS/2) clk = ~clk;

    sat_thresh_counter i_sat_thresh_counter (
        .clk(clk), .rst_n(rst_n), .inc_req(a_inc), .dec_req(a_dec),
        .inc_val(a_iv), .dec_val(a_dv), .sw_wr_en(a_we), .sw_wr_data(a_wd),
        .sw_rd_data(a_cnt), .inc_thr_hit(a_ith), .dec_thr_hit(a_dth),
        .ovf_pulse(a_ov), .udf_pulse(a_uf)
    );

    sat_thresh_counter #(
        .CNT_W(8), .STEP_W(8), .INC_PORT(1'b1), .DEC_PORT(1'b1),
        .INC_SAT_EN(1'b0), .DEC_SAT_EN(1'b0), .INC_SAT(8'd255), .DEC_SAT(8'd0),
        .INC_THR(8'd200), .DEC_THR(8'd3)
    ) i_sat_thresh_counter_wrap (
        .clk(clk), .rst_n(rst_n), .inc_req(b_inc), .dec_req(b_dec),
        .inc_val(b_iv), .dec_val(b_dv), .sw_wr_en(b_we), .sw_wr_data(b_wd),
        .sw_rd_data(b_cnt), .inc_thr_hit(b_ith), .dec_thr_hit(b_dth),
        .ovf_pulse(b_ov), .udf_pulse(b_uf)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: applies one operation and queues the expected outcome.
    task automatic op(int s, bit inc, bit dec, int iv, int dv, bit we, longint wd, string req);
        longint mx, ist, dst, sum, nc, up, dn;
        bit     ov, uf;
        exp_t   e;
        @(negedge clk);
        a_inc = 0; a_dec = 0; a_we = 0; b_inc = 0; b_dec = 0; b_we = 0;
        if (s == 0) begin
            a_inc = inc; a_dec = dec; a_iv = 8'(iv); a_dv = 8'(dv); a_we = we; a_wd = 32'(wd);
        end else begin
            b_inc = inc; b_dec = dec; b_iv = 8'(iv); b_dv = 8'(dv); b_we = we; b_wd = 8'(wd);
        end
        mx  = (s == 0) ? 64'hFFFF_FFFF : 255;
        ist = (s == 0) ? 2 : iv;
        dst = (s == 0) ? 2 : dv;
        up  = inc ? ist : 0;
        dn  = dec ? dst : 0;
        sum = mcnt[s] + up - dn;
        ov = 0; uf = 0; nc = sum;
        if (we) nc = wd;
        else if (up > dn) begin
            if (s == 0 && sum > 15) nc = 15;
            else if (sum > mx) begin nc = sum - (mx + 1); ov = 1; end
        end else if (dn > up) begin
            if (s == 0 && sum < 5) nc = 5;
            else if (sum < 0) begin nc = sum + (mx + 1); uf = 1; end
        end
        mcnt[s] = nc;
        e.sel = s; e.cnt = nc; e.ov = ov; e.uf = uf; e.req = req;
        e.ith = (s == 0) ? (nc >= 10) : (nc >= 200);
        e.dth = (s == 0) ? (nc <= 10) : (nc <= 3);
        q.push_back(e);
    endtask

    // Monitor: compares the queued expectation a quarter cycle after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_NS/4);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                if (e.sel == 0) begin
                    chk(e.req, "count", longint'(a_cnt), e.cnt);
                    chk(e.req, "ovf", longint'(a_ov), longint'(e.ov));
                    chk(e.req, "udf", longint'(a_uf), longint'(e.uf));
                    chk(e.req, "inc_thr", longint'(a_ith), longint'(e.ith));
                    chk(e.req, "dec_thr", longint'(a_dth), longint'(e.dth));
                end else begin
                    chk(e.req, "count", longint'(b_cnt), e.cnt);
                    chk(e.req, "ovf", longint'(b_ov), longint'(e.ov));
                    chk(e.req, "udf", longint'(b_uf), longint'(e.uf));
                    chk(e.req, "inc_thr", longint'(b_ith), longint'(e.ith));
                    chk(e.req, "dec_thr", longint'(b_dth), longint'(e.dth));
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_NS * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        mcnt[0] = 0;
        mcnt[1] = 0;
        repeat (3) @(posedge clk);
        #(CLK_NS/4);
        // R1: reset state of both instances
        chk("R1", "count", longint'(a_cnt), 0);
        chk("R1", "ovf", longint'(a_ov), 0);
        chk("R1", "udf", longint'(a_uf), 0);
        chk("R1", "inc_thr", longint'(a_ith), 0);
        chk("R1", "dec_thr", longint'(a_dth), 1);
        chk("R1", "count_w", longint'(b_cnt), 0);
        chk("R1", "ovf_w", longint'(b_ov), 0);
        @(negedge clk);
        rst_n = 1'b1;

        op(0, 1, 0, 0, 0, 0, 0, "R2");     // 2
        op(0, 1, 0, 0, 0, 0, 0, "R2");     // 4
        op(0, 1, 0, 0, 0, 0, 0, "R2");     // 6
        op(0, 1, 0, 0, 0, 0, 0, "R9");     // 8
        op(0, 1, 0, 0, 0, 0, 0, "R8");     // 10, both flags
        op(0, 1, 0, 0, 0, 0, 0, "R9");     // 12
        op(0, 1, 0, 0, 0, 0, 0, "R2");     // 14
        op(0, 1, 0, 0, 0, 0, 0, "R6");     // clamp 15
        op(0, 1, 0, 0, 0, 0, 0, "R10");    // held at 15, no ovf
        op(0, 1, 0, 0, 0, 1, 7, "R5");     // load wins over inc
        op(0, 1, 1, 0, 0, 0, 0, "R4");     // net zero
        op(0, 0, 1, 0, 0, 0, 0, "R3");     // 5
        op(0, 0, 1, 0, 0, 0, 0, "R7");     // clamp 5
        op(0, 0, 1, 0, 0, 0, 0, "R11");    // held, no udf
        op(0, 0, 0, 0, 0, 0, 0, "R12");    // idle
        op(0, 0, 1, 0, 0, 1, 100, "R5");   // load wins over dec
        op(0, 0, 1, 0, 0, 0, 0, "R3");     // 98

        op(1, 0, 0, 0, 0, 1, 250, "R5");   // load 250
        op(1, 1, 0, 10, 0, 0, 0, "R10");   // wrap to 4, ovf
        op(1, 0, 0, 0, 0, 0, 0, "R10");    // pulse cleared
        op(1, 0, 1, 0, 7, 0, 0, "R11");    // wrap to 253, udf
        op(1, 0, 0, 0, 0, 0, 0, "R11");    // pulse cleared
        op(1, 1, 1, 5, 3, 0, 0, "R4");     // 255
        op(1, 1, 0, 1, 0, 0, 0, "R10");    // wrap to 0
        op(1, 1, 1, 2, 9, 0, 0, "R4");     // net -7 wraps to 249
        op(1, 1, 0, 3, 0, 0, 0, "R2");     // port step 252
        op(1, 0, 1, 0, 250, 0, 0, "R3");   // port step 2, dec flag
        op(1, 0, 0, 0, 0, 0, 0, "R12");

        @(negedge clk);
        a_inc = 0; a_dec = 0; a_we = 0; b_inc = 0; b_dec = 0; b_we = 0;
        repeat (3) @(posedge clk);
        #(CLK_NS/2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule